// File: doc/BRIEF.md
# Power Switch Short Monitor with Turn-On Blanking

This block watches the six power switches of a three-phase bridge for a
short (desaturation) condition. For each switch it receives the effective
on-command and a digital bit from an external over-threshold comparator. The
comparator bit is meaningless while a switch is off or still turning on. So
each monitor ignores it until a programmable number of clock cycles has passed
since the command went high. Only after that window can a short be declared.

A declared short drives a per-switch trip output that the gate logic uses to
force that one switch off. The trip stays asserted while the command stays
high, and it is released only when the command is seen low. A later rising
command starts a fresh blanking window. Trips on high-side switches only
protect the switch. Trips on low-side switches also set a latched per-phase
event bit for the fault register, and a combined low-side fault flag. These
event bits clear on any of three clear inputs (reset request, end of a serial
read, internal supply fail), or when the phase's low-side command is low. In
every case the comparator for that switch must have dropped.

Top module: `switch_short_guard`

## Requirements
- R1: While `rst_n` is sampled low, every trip output, every event bit and `ls_flag` are 0 after that edge.
- R2: While a switch's on-command is low, its comparator bit has no effect: its trip output stays 0.
- R3: Counting the first rising edge that samples a switch's on-command high as edge 1, the comparator is ignored at edges 1 through BLANK_CYC+1. If the command is sampled low during that window, the window is abandoned and no trip or event results.
- R4: If the comparator is sampled high at edge BLANK_CYC+2 or later while the command is still high, the switch's trip output is 1 after that edge.
- R5: A trip affects only the output of the switch that tripped. Bit i of `hs_trip`, `ls_trip`, `hs_on`, `ls_on`, `hs_over`, `ls_over` and `ls_event` belongs to phase i (0 = A, 1 = B, 2 = C).
- R6: Once set, a trip stays 1 while the command remains high, even after the comparator drops. It is 0 after the first edge that samples the command low.
- R7: High-side trips never change `ls_event` or `ls_flag`.
- R8: A low-side trip on phase i sets `ls_event[i]` at the same edge as `ls_trip[i]`. `ls_flag` is 1 exactly when any `ls_event` bit is 1.
- R9: A set `ls_event[i]` is cleared at an edge where `ls_over[i]` is low and either one of `clr_reset`, `clr_read_done`, `clr_supply_fail` is high or `ls_on[i]` is low. Otherwise it holds, including while `ls_over[i]` is still high.
- R10: Each new rising command restarts the blanking count from zero. A switch that has been released by a low command blanks again in full before it can trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hs_on | input | N_PHASE | High-side effective on-commands |
| ls_on | input | N_PHASE | Low-side effective on-commands |
| hs_over | input | N_PHASE | High-side comparator bits, 1 = above threshold |
| ls_over | input | N_PHASE | Low-side comparator bits, 1 = above threshold |
| clr_reset | input | 1 | Event clear from the reset path |
| clr_read_done | input | 1 | Event clear at completion of a serial read |
| clr_supply_fail | input | 1 | Event clear from internal supply fail |
| hs_trip | output | N_PHASE | High-side force-off outputs |
| ls_trip | output | N_PHASE | Low-side force-off outputs |
| ls_event | output | N_PHASE | Latched low-side short events per phase |
| ls_flag | output | 1 | Low-side short fault flag |

## Verification
The hardest cases sit exactly at the end of the blanking window. These are a comparator pulse that lands on the last ignored edge, and the edge just after it. A command that drops one cycle short of the window is also hard to reach. Random toggling almost never lines up on those edges. So the bench drives directed sequences that count edges from the command rise and place the comparator pulse on edge BLANK_CYC+1 and then on BLANK_CYC+2. It also tries to clear an event while the comparator is still high. Long random runs then mix commands, comparators and clears, and compare every output each cycle against an edge-counting model.

// File: rtl/ssg_pkg.sv
// Shared types for the switch short monitor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package ssg_pkg;

    // Per-switch monitor states
    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,   // switch commanded off, monitor inactive
        MON_BLANK = 2'd1,   // turning on, comparator masked
        MON_WATCH = 2'd2,   // comparator evaluated every cycle
        MON_TRIP  = 2'd3    // short declared, switch forced off
    } mon_state_t;

endpackage

// File: rtl/ssg_blank_timer.sv
// Blanking counter for one switch.
// Counts cycles while run is high and stops at BLANK_CYC-1, where done is set.
// Assumes: clr is asserted in every cycle the owner is not blanking, so each
// new blanking window starts from zero.
module ssg_blank_timer #(
    parameter int BLANK_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (BLANK_CYC < 2) ? 1 : $clog2(BLANK_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLANK_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign done = (cnt == LAST);

    // Count up during blanking, hold at the terminal value, clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Counter never passes the terminal value (blank window length, R3)
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // A cleared counter starts from zero (restart on new command, R10)
    p_cnt_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/ssg_monitor.sv
// Short monitor for one power switch.
// Masks the comparator for the blank window after each turn-on, then declares
// a short if the comparator is high while the switch is still commanded on.
// The trip holds until the command is sampled low.
// Assumes: 'over' is already synchronised to clk.
module ssg_monitor
    import ssg_pkg::*;
#(
    parameter int BLANK_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic on_cmd,
    input  logic over,
    output logic trip,
    output logic trip_set
);
    mon_state_t st, st_nx;
    logic       blank_done;

    ssg_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st != MON_BLANK),
        .run   (st == MON_BLANK),
        .done  (blank_done)
    );

    // A short is declared on this edge
    assign trip_set = (st == MON_WATCH) && on_cmd && over;
    assign trip     = (st == MON_TRIP);

    // Next-state selection
    always_comb begin
        st_nx = st;
        if (!on_cmd) begin
            st_nx = MON_IDLE;
        end else begin
            unique case (st)
                MON_IDLE:  st_nx = MON_BLANK;
                MON_BLANK: st_nx = blank_done ? MON_WATCH : MON_BLANK;
                MON_WATCH: st_nx = over ? MON_TRIP : MON_WATCH;
                MON_TRIP:  st_nx = MON_TRIP;
                default:   st_nx = MON_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= MON_IDLE;
        else        st <= st_nx;
    end

    // A trip only rises on a sampled comparator while commanded on (R2, R4)
    p_trip_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(trip)) |-> ($past(on_cmd) && $past(over)));

    // Trip is held while the command stays high (R6)
    p_trip_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && on_cmd) |=> trip);

    // Trip released once the command is sampled low (R6)
    p_trip_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !on_cmd |=> !trip);

    // Never trip straight out of the blank window (R3)
    p_no_trip_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == MON_BLANK) |=> !trip);

endmodule

// File: rtl/ssg_event_latch.sv
// Latched low-side short event for one phase.
// Sets on a low-side trip; clears on a clear request or a low command, but
// only once the comparator has dropped. A set takes priority.
// Assumes: trip_set comes from the low-side monitor of the same phase.
module ssg_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_set,
    input  logic clr_any,
    input  logic on_cmd,
    input  logic over,
    output logic ev
);
    // Set/clear/hold of the event bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev <= 1'b0;
        end else if (trip_set) begin
            ev <= 1'b1;
        end else if ((clr_any || !on_cmd) && !over) begin
            ev <= 1'b0;
        end
    end

    // Event only rises from a low-side trip (R8)
    p_ev_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(ev)) |-> $past(trip_set));

    // Event never clears while the comparator is still high (R9)
    p_ev_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ev)) |-> !$past(over));

endmodule

// File: rtl/switch_short_guard.sv
// Six-switch short monitor: one monitor per high- and low-side switch,
// per-phase latched low-side events and a combined low-side flag.
// Assumes: all inputs synchronous to clk; comparator bits from outside.
module switch_short_guard #(
    parameter int N_PHASE   = 3,
    parameter int BLANK_CYC = 300
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PHASE-1:0] hs_on,
    input  logic [N_PHASE-1:0] ls_on,
    input  logic [N_PHASE-1:0] hs_over,
    input  logic [N_PHASE-1:0] ls_over,
    input  logic               clr_reset,
    input  logic               clr_read_done,
    input  logic               clr_supply_fail,
    output logic [N_PHASE-1:0] hs_trip,
    output logic [N_PHASE-1:0] ls_trip,
    output logic [N_PHASE-1:0] ls_event,
    output logic               ls_flag
);
    logic               clr_any;
    logic [N_PHASE-1:0] hs_set;
    logic [N_PHASE-1:0] ls_set;

    assign clr_any = clr_reset | clr_read_done | clr_supply_fail;

    for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
        ssg_monitor #(.BLANK_CYC(BLANK_CYC)) i_hs_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .on_cmd   (hs_on[g]),
            .over     (hs_over[g]),
            .trip     (hs_trip[g]),
            .trip_set (hs_set[g])
        );

        ssg_monitor #(.BLANK_CYC(BLANK_CYC)) i_ls_mon (
            .clk      (clk),
            .rst_n    (rst_n),
            .on_cmd   (ls_on[g]),
            .over     (ls_over[g]),
            .trip     (ls_trip[g]),
            .trip_set (ls_set[g])
        );

        ssg_event_latch i_ev (
            .clk      (clk),
            .rst_n    (rst_n),
            .trip_set (ls_set[g]),
            .clr_any  (clr_any),
            .on_cmd   (ls_on[g]),
            .over     (ls_over[g]),
            .ev       (ls_event[g])
        );

        // Low-side event and trip rise together (R8)
        p_ev_with_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(ls_event[g])) |-> $rose(ls_trip[g]));
    end

    // Combined low-side fault flag
    assign ls_flag = |ls_event;

    // High-side trip activity alone never raises the flag (R7)
    p_hs_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(ls_flag)) |-> ($past(ls_set) != '0));

    // The unused high-side set pulses are kept for symmetry; observed here (R7)
    p_hs_set_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_set != '0) |=> (hs_trip != '0));

endmodule

// File: tb/test_switch_short_guard.sv
`timescale 1ns/1ps
module test_switch_short_guard;
    localparam int NP  = 3;
    localparam int BLK = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] hs_on = '0, ls_on = '0, hs_over = '0, ls_over = '0;
    logic clr_reset = 1'b0, clr_read_done = 1'b0, clr_supply_fail = 1'b0;
    logic [NP-1:0] hs_trip, ls_trip, ls_event;
    logic ls_flag;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    int      m_cnt [6];
    bit      m_trip [6];
    bit [2:0] m_ev;

    always #5 clk = ~clk;

    switch_short_guard #(.N_PHASE(NP), .BLANK_CYC(BLK)) i_switch_short_guard (
        .clk(clk), .rst_n(rst_n),
        .hs_on(hs_on), .ls_on(ls_on), .hs_over(hs_over), .ls_over(ls_over),
        .clr_reset(clr_reset), .clr_read_done(clr_read_done),
        .clr_supply_fail(clr_supply_fail),
        .hs_trip(hs_trip), .ls_trip(ls_trip), .ls_event(ls_event), .ls_flag(ls_flag)
    );

    function automatic logic [9:0] model_out();
        logic [9:0] v;
        for (int j = 0; j < 3; j++) begin
            v[9-j] = 1'b0;
        end
        v[9:7] = {m_trip[2], m_trip[1], m_trip[0]};
        v[6:4] = {m_trip[5], m_trip[4], m_trip[3]};
        v[3:1] = m_ev;
        v[0]   = |m_ev;
        return v;
    endfunction

    task automatic model_edge();
        logic [5:0] on, ov;
        bit nt [6];
        bit clr;
        on  = {ls_on, hs_on};
        ov  = {ls_over, hs_over};
        clr = clr_reset | clr_read_done | clr_supply_fail;
        if (!rst_n) begin
            for (int j = 0; j < 6; j++) begin m_cnt[j] = 0; m_trip[j] = 0; end
            m_ev = '0;
            return;
        end
        for (int j = 0; j < 6; j++) begin
            bit old;
            old = m_trip[j];
            if (!on[j]) begin
                m_cnt[j] = 0; m_trip[j] = 0;
            end else begin
                if (m_cnt[j] < BLK + 2) m_cnt[j]++;
                if (m_cnt[j] >= BLK + 2 && ov[j]) m_trip[j] = 1;
            end
            nt[j] = !old && m_trip[j];
        end
        for (int i = 0; i < 3; i++) begin
            if (nt[3+i]) m_ev[i] = 1'b1;
            else if ((clr || !ls_on[i]) && !ls_over[i]) m_ev[i] = 1'b0;
        end
    endtask

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [9:0] dut_out();
        return {hs_trip, ls_trip, ls_event, ls_flag};
    endfunction

    // One clock edge, model update, full output comparison
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag, dut_out(), model_out());
    endtask

    task automatic expect_bit(input string tag, input logic got, input logic exp);
        check(tag, {9'd0, got}, {9'd0, exp});
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1742));
        #1;
        // R1: reset state
        step("R1"); step("R1");
        check("R1 reset outputs", dut_out(), 10'd0);
        rst_n = 1'b1;
        step("R1");

        // R2: comparators high, commands low
        ls_over = '1; hs_over = '1;
        for (int k = 0; k < 10; k++) step("R2");
        expect_bit("R2 no trip while off", |{hs_trip, ls_trip}, 1'b0);

        // R3: turn-off inside blanking aborts
        ls_on[0] = 1'b1;
        for (int k = 0; k < 4; k++) step("R3");
        ls_on[0] = 1'b0;
        step("R3");
        ls_over = '0; hs_over = '0;
        for (int k = 0; k < BLK + 4; k++) step("R3");
        expect_bit("R3 abort no event", ls_event[0], 1'b0);

        // R3/R4: pulse on the last ignored edge, then the first evaluated one
        ls_on[1] = 1'b1;
        for (int k = 1; k <= BLK + 1; k++) begin
            ls_over[1] = (k == BLK + 1);
            step("R3");
        end
        expect_bit("R3 last blank edge ignored", ls_trip[1], 1'b0);
        ls_over[1] = 1'b1;
        step("R4");
        expect_bit("R4 trip after blank", ls_trip[1], 1'b1);
        check("R8 event on phase B", {7'd0, ls_event}, 10'b0000000_010);
        expect_bit("R8 flag", ls_flag, 1'b1);
        expect_bit("R5 other switches", |{hs_trip, ls_trip[0], ls_trip[2]}, 1'b0);

        // R6: hold after comparator drops
        ls_over[1] = 1'b0;
        for (int k = 0; k < 3; k++) step("R6");
        expect_bit("R6 held", ls_trip[1], 1'b1);

        // R9: clear refused while comparator high, accepted when low
        ls_over[1] = 1'b1; clr_read_done = 1'b1;
        step("R9");
        expect_bit("R9 clear blocked", ls_event[1], 1'b1);
        ls_over[1] = 1'b0;
        step("R9");
        clr_read_done = 1'b0;
        expect_bit("R9 cleared", ls_event[1], 1'b0);
        expect_bit("R6 still held", ls_trip[1], 1'b1);

        // R6/R10: release, re-arm with full blanking
        ls_on[1] = 1'b0;
        step("R6");
        expect_bit("R6 released", ls_trip[1], 1'b0);
        ls_on[1] = 1'b1; ls_over[1] = 1'b1;
        for (int k = 0; k < BLK + 1; k++) step("R10");
        expect_bit("R10 fresh blank", ls_trip[1], 1'b0);
        step("R10");
        expect_bit("R10 trips again", ls_trip[1], 1'b1);

        // R9: clear by low command once comparator drops
        ls_over[1] = 1'b0; ls_on[1] = 1'b0;
        step("R9");
        expect_bit("R9 cleared by command", ls_event[1], 1'b0);

        // R7: high-side trip is not reported
        hs_on[0] = 1'b1; hs_over[0] = 1'b1;
        for (int k = 0; k < BLK + 3; k++) step("R7");
        expect_bit("R7 hs trip", hs_trip[0], 1'b1);
        check("R7 no report", {6'd0, ls_event, ls_flag}, 10'd0);
        hs_on = '0; hs_over = '0;
        step("R7");

        // Random mix with all clears
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NP; i++) begin
                if ($urandom_range(0, 15) == 0) hs_on[i] = ~hs_on[i];
                if ($urandom_range(0, 15) == 0) ls_on[i] = ~ls_on[i];
                if ($urandom_range(0, 5) == 0)  hs_over[i] = ~hs_over[i];
                if ($urandom_range(0, 5) == 0)  ls_over[i] = ~ls_over[i];
            end
            clr_reset       = ($urandom_range(0, 60) == 0);
            clr_read_done   = ($urandom_range(0, 40) == 0);
            clr_supply_fail = ($urandom_range(0, 80) == 0);
            step("R2/R4/R5/R6/R8/R9/R10 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule